// File: doc/BRIEF.md
# SD Card Clock Two-Stage Divider

This block derives the SD card clock from a faster base clock. The division runs in two stages in series. The first stage is a power-of-two prescaler. The second stage is a linear divisor that counts the prescaler's wrap pulses. Both settings come from one packed control word. A separate card-clock enable starts and stops the output.

The block produces two outputs: a single-cycle enable pulse at the start of every output period, and a registered divided clock with a near-50% duty cycle. The divide settings are captured only while the divider is idle with the enable low. Firmware therefore drops the enable, rewrites the word and raises the enable again. Turning the enable off lets the current period run to its end, so the card never sees a shortened pulse.

A stable flag rises once a whole period has completed under the active settings.

Top module: `sdclk_divider`

## Requirements
- R1: The prescaler code sits in control bits 15:8. A code of zero selects a prescale of 1. Otherwise the prescale is twice the weight of the highest set bit, so code 0x01 gives 2 and code 0x80 gives 256. Lower set bits are ignored.
- R2: The divisor code sits in control bits 7:4, and the divisor is the code plus one (1 to 16).
- R3: While running, card_clk_tick pulses for one base cycle exactly once every prescale×divisor base cycles.
- R4: card_clk is high for the first ceil(N/2) base cycles of each N-cycle period, starting with the tick cycle, and low for the rest. With N=1 it stays high.
- R5: The control word is captured only while the divider is idle and the enable is low. Writes made while running leave the period unchanged.
- R6: The first clock edge that samples the enable high while idle starts a period. After that edge, card_clk and card_clk_tick are both 1.
- R7: When the enable goes low, the divider finishes the current period and then holds card_clk low. No high phase is shortened.
- R8: clk_stable goes high together with the tick that closes the first complete period after start. It is low whenever the enable is low.
- R9: During and just after reset, card_clk, card_clk_tick and clk_stable are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| card_clk_en | input | 1 | Card clock enable; low while the settings are changed |
| ctrl_word | input | 12 | Control bits 15:4: prescaler code in 15:8, divisor code in 7:4 |
| card_clk | output | 1 | Divided card clock, registered |
| card_clk_tick | output | 1 | One-cycle pulse at the start of each output period |
| clk_stable | output | 1 | A full period has completed under the held settings |

## Verification
The checker looks at every cycle for four things:
- a rising card clock always coincides with a tick;
- every tick falls in a high phase;
- the flag drops after the enable is low and can rise only on a tick;
- the held settings do not move while the divider runs.

The exact period length for each prescaler and divisor encoding, the duty split for odd ratios, and the drain-to-end-of-period behaviour show only in the bench scenarios. There, a cycle-level reference model and measured tick spacing cover both random and directed settings.

// File: rtl/sdclk_pkg.sv
package sdclk_pkg;
    localparam int DEF_PRE_W   = 8;
    localparam int DEF_DIV_W   = 4;
    localparam int DEF_DIV_LSB = 4;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } run_e;
endpackage

// File: rtl/sdclk_cfg_decode.sv
module sdclk_cfg_decode #(
    parameter int PRE_W = 8,
    parameter int DIV_W = 4,
    localparam int SHW  = $clog2(PRE_W + 1),
    localparam int NW   = PRE_W + DIV_W + 1
) (
    input  logic [PRE_W-1:0] pre_code,
    input  logic [DIV_W-1:0] div_code,
    output logic [SHW-1:0]   shift,
    output logic [PRE_W-1:0] pre_lim,
    output logic [DIV_W-1:0] div_lim,
    output logic [NW-1:0]    half
);
    logic [PRE_W:0] span;
    logic [NW-1:0]  ratio;

    // highest set bit wins; zero code bypasses the prescaler
    always_comb begin
        shift = '0;
        for (int i = 0; i < PRE_W; i++) begin
            if (pre_code[i]) shift = SHW'(i + 1);
        end
        span    = (PRE_W+1)'(1) << shift;
        pre_lim = PRE_W'(span - (PRE_W+1)'(1));
        div_lim = div_code;
        ratio   = (NW'(div_code) + NW'(1)) << shift;
        half    = (ratio + NW'(1)) >> 1;
    end
endmodule

// File: rtl/sdclk_stage_counter.sv
module sdclk_stage_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         adv,
    input  logic [W-1:0] lim,
    output logic [W-1:0] cnt_q,
    output logic [W-1:0] cnt_d,
    output logic         wrap
);
    always_comb begin
        wrap  = adv && (cnt_q == lim);
        cnt_d = cnt_q;
        if (clear)     cnt_d = '0;
        else if (wrap) cnt_d = '0;
        else if (adv)  cnt_d = cnt_q + W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/sdclk_divider.sv
module sdclk_divider
    import sdclk_pkg::*;
#(
    parameter int PRE_W    = DEF_PRE_W,
    parameter int DIV_W    = DEF_DIV_W,
    parameter int DIV_LSB  = DEF_DIV_LSB,
    localparam int PRE_LSB = DIV_LSB + DIV_W,
    localparam int CFG_MSB = PRE_LSB + PRE_W - 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   card_clk_en,
    input  logic [CFG_MSB:DIV_LSB] ctrl_word,
    output logic                   card_clk,
    output logic                   card_clk_tick,
    output logic                   clk_stable
);
    localparam int SHW  = $clog2(PRE_W + 1);
    localparam int NW   = PRE_W + DIV_W + 1;
    localparam int POSW = PRE_W + DIV_W;

    typedef struct packed {
        run_e             run;
        logic             clk;
        logic             tick;
        logic             stable;
        logic [PRE_W-1:0] pre_code;
        logic [DIV_W-1:0] div_code;
    } state_t;

    state_t st_d, st_q;

    logic [SHW-1:0]   shift;
    logic [PRE_W-1:0] pre_lim, pre_q, pre_d;
    logic [DIV_W-1:0] div_lim, div_q, div_d;
    logic [NW-1:0]    half;
    logic             pre_wrap, div_wrap, running, stop, last;
    logic [POSW-1:0]  pos_next;
    logic [PRE_W+DIV_W-1:0] held_cfg;

    assign running  = (st_q.run == ST_RUN);
    assign held_cfg = {st_q.pre_code, st_q.div_code};

    sdclk_cfg_decode #(.PRE_W(PRE_W), .DIV_W(DIV_W)) u_dec (
        .pre_code (st_q.pre_code),
        .div_code (st_q.div_code),
        .shift    (shift),
        .pre_lim  (pre_lim),
        .div_lim  (div_lim),
        .half     (half)
    );

    sdclk_stage_counter #(.W(PRE_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (!running),
        .adv   (running),
        .lim   (pre_lim),
        .cnt_q (pre_q),
        .cnt_d (pre_d),
        .wrap  (pre_wrap)
    );

    sdclk_stage_counter #(.W(DIV_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (!running),
        .adv   (running && pre_wrap),
        .lim   (div_lim),
        .cnt_q (div_q),
        .cnt_d (div_d),
        .wrap  (div_wrap)
    );

    always_comb begin
        st_d     = st_q;
        last     = (pre_q == pre_lim) && (div_q == div_lim);
        stop     = running && !card_clk_en && last;
        pos_next = (POSW'(div_d) << shift) | POSW'(pre_d);

        if (!running) begin
            st_d.clk  = card_clk_en;
            st_d.tick = card_clk_en;
            if (card_clk_en) begin
                st_d.run = ST_RUN;
            end else begin
                st_d.pre_code = ctrl_word[CFG_MSB:PRE_LSB];
                st_d.div_code = ctrl_word[PRE_LSB-1:DIV_LSB];
            end
        end else if (stop) begin
            st_d.run  = ST_IDLE;
            st_d.clk  = 1'b0;
            st_d.tick = 1'b0;
        end else begin
            st_d.clk  = (NW'(pos_next) < half);
            st_d.tick = pre_wrap && div_wrap;
        end

        st_d.stable = card_clk_en &&
                      (st_q.stable || (running && pre_wrap && div_wrap));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign card_clk      = st_q.clk;
    assign card_clk_tick = st_q.tick;
    assign clk_stable    = st_q.stable;
endmodule

// File: rtl/sdclk_divider_chk.sv
module sdclk_divider_chk #(
    parameter int CW = 12
) (
    input logic          clk,
    input logic          rst_n,
    input logic          card_clk_en,
    input logic          card_clk,
    input logic          card_clk_tick,
    input logic          clk_stable,
    input logic          running,
    input logic [CW-1:0] held_cfg
);
    assert_rise_on_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(card_clk) |-> card_clk_tick);

    assert_tick_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        card_clk_tick |-> card_clk);

    assert_stable_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !card_clk_en |=> !clk_stable);

    assert_stable_on_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_stable) |-> card_clk_tick);

    assert_cfg_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
        running |=> $stable(held_cfg));
endmodule

bind sdclk_divider sdclk_divider_chk #(.CW(PRE_W + DIV_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .card_clk_en   (card_clk_en),
    .card_clk      (card_clk),
    .card_clk_tick (card_clk_tick),
    .clk_stable    (clk_stable),
    .running       (running),
    .held_cfg      (held_cfg)
);

// File: tb/sim_sdclk_divider.sv
module sim_sdclk_divider;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic [15:4] cw = '0;
    logic        card_clk, card_clk_tick, clk_stable;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 0;

    sdclk_divider u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .card_clk_en   (en),
        .ctrl_word     (cw),
        .card_clk      (card_clk),
        .card_clk_tick (card_clk_tick),
        .clk_stable    (clk_stable)
    );

    always #10 clk = ~clk;

    function automatic int prescale_of(logic [7:0] pc);
        int p = 1;
        for (int i = 0; i < 8; i++) if (pc[i]) p = 2 << i;
        return p;
    endfunction

    function automatic int ratio_of(logic [15:4] w);
        return prescale_of(w[15:8]) * (int'(w[7:4]) + 1);
    endfunction

    // reference model, advanced at each base edge
    bit m_run = 0, m_clk = 0, m_tick = 0, m_stab = 0;
    int m_pos = 0, m_n = 1;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_run = 0; m_clk = 0; m_tick = 0; m_stab = 0; m_pos = 0;
            m_n = ratio_of(cw);
        end else if (!m_run) begin
            if (en) begin
                m_run = 1; m_pos = 0; m_clk = 1; m_tick = 1;
            end else begin
                m_n = ratio_of(cw); m_clk = 0; m_tick = 0;
            end
            m_stab = 0;
        end else if (!en && m_pos == m_n - 1) begin
            m_run = 0; m_pos = 0; m_clk = 0; m_tick = 0; m_stab = 0;
        end else begin
            m_pos  = (m_pos + 1) % m_n;
            m_tick = (m_pos == 0);
            m_clk  = (m_pos < (m_n + 1) / 2);
            m_stab = en && (m_stab || m_tick);
        end
    end

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        cyc++;
        if (rst_n && !done) begin
            check(card_clk_tick == m_tick, "R3 tick", card_clk_tick, m_tick);
            check(card_clk == m_clk, "R4 card_clk", card_clk, m_clk);
            check(clk_stable == m_stab, "R8 stable", clk_stable, m_stab);
        end
        if (cyc > 190000 && !done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog: actual %0d expected <190000", cyc);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic measure(output int p);
        p = 0;
        do @(negedge clk); while (!card_clk_tick);
        do begin @(negedge clk); p++; end while (!card_clk_tick);
    endtask

    task automatic directed_period(logic [15:4] w, string req);
        int p;
        @(negedge clk); en = 0; cw = w;
        idle(ratio_of(cw) + 3);
        en = 1;
        @(negedge clk);
        check(card_clk && card_clk_tick, "R6 start", {card_clk, card_clk_tick}, 3);
        measure(p);
        check(p == ratio_of(w), req, p, ratio_of(w));
        en = 0;
        idle(ratio_of(w) + 2);
        check(!card_clk, "R7 stopped low", card_clk, 0);
    endtask

    initial begin
        int p;
        void'($urandom(32'd20240611));
        idle(3);
        check(!card_clk && !card_clk_tick && !clk_stable, "R9 reset",
              {card_clk, card_clk_tick, clk_stable}, 0);
        rst_n = 1;
        idle(2);
        check(!card_clk && !clk_stable, "R9 after reset", {card_clk, clk_stable}, 0);

        // R1 prescaler encodings, R2 divisor encodings
        directed_period({8'h00, 4'h0}, "R1 bypass N=1");
        directed_period({8'h00, 4'h2}, "R2 odd N=3");
        directed_period({8'h01, 4'h0}, "R1 prescale 2");
        directed_period({8'h06, 4'h1}, "R1 msb wins 8x2");
        directed_period({8'h10, 4'hF}, "R2 divisor 16");
        directed_period({8'h80, 4'hF}, "R1 max 256x16");

        // R5: write while running is ignored
        @(negedge clk); cw = {8'h02, 4'h2}; idle(20);
        en = 1; idle(3);
        cw = {8'h01, 4'h0};
        measure(p);
        check(p == 12, "R5 ignore write", p, 12);
        // R7: disable mid-period, high phase not cut
        idle(2); en = 0;
        idle(14);
        check(!card_clk, "R7 drained", card_clk, 0);
        en = 1; measure(p);
        check(p == 2, "R5 new setting", p, 2);
        en = 0; idle(4);

        // random settings and enable windows
        for (int k = 0; k < 40; k++) begin
            int n;
            @(negedge clk);
            cw = {3'b000, 5'($urandom_range(0, 31)), 4'($urandom_range(0, 15))};
            idle($urandom_range(0, 3));
            en = 1;
            n = ratio_of(cw);
            if ($urandom_range(0, 3) == 0) cw = 12'($urandom);
            idle(2 * n + $urandom_range(0, n + 4));
            en = 0;
            idle($urandom_range(1, n + 4));
        end
        en = 0;
        idle(600);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule